// File: doc/BRIEF.md
# Three-Wire Serial Bus Monitor

This block watches a three-wire, half-duplex synchronous serial bus (active-high select, serial clock, controller-to-target data, target-to-controller data) from a faster system clock. It never drives the bus. All four lines pass through two-flop synchronizers. Line edges are found by comparing each synchronized sample with the one before it.

Every interval during which select is high is one transaction. The first rising serial clock inside that interval decides what kind it is. If the incoming data line is high at that edge, the transaction is a bit transfer. The monitor then streams one sampled pair per bit and marks the leading start bit. It also collects the bits into a small buffer, which it presents once select drops. If the data line is low at that first edge, or if the clock never rises at all, the transaction is a ready/busy poll. In that case the monitor reports the level of the outgoing data line.

Protocol irregularities are kept in a sticky warning vector. The vector is wiped when the next select interval opens.

Top module: `uwire_monitor`

## Requirements
- R1: After reset, every pulse output, `warn` and `frame_count` are zero.
- R2: If the synchronized clock is already high when select rises, `warn[0]` is set. That high level does not count as a rising clock edge; only a later low-to-high transition does.
- R3: The controller-to-target bit of each bit is the value of `si_i` at that bit's rising clock edge.
- R4: The target-to-controller bit of each bit is the value of `so_i` at the falling clock edge that follows that bit's rising edge.
- R5: The transaction is a bit transfer when `si_i` is high at the first rising clock edge. The first reported bit then has `bit_is_start`=1, and all later bits have it 0. Otherwise the transaction is a poll and produces no `bit_valid`.
- R6: A bit is reported with a `bit_valid` pulse when the next rising clock edge arrives, or when select falls while the clock is low. If select falls while the clock is high, the still-open bit is discarded.
- R7: In a poll (including before the first clock rise), each rise of `so_i` while selected gives a `status_valid` pulse with `status_ready`=1. When select falls, `status_valid` pulses with `status_ready` equal to the `so_i` level (1 = ready, 0 = busy).
- R8: One cycle after a bit transfer's last `bit_valid` at select fall, `frame_valid` pulses for exactly one cycle. `frame_count` holds the number of stored bits. Bit i of the transfer sits at position i of `frame_si`/`frame_so`, and unused positions are 0.
- R9: Bits beyond `MAX_BITS` are still streamed but not stored. `frame_count` stops at `MAX_BITS` and `warn[1]` (overflow) is set.
- R10: `warn` bits stay set until the next select rise, which clears them (except that `warn[0]` is set again there if R2 applies).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Bus select, active high |
| sk_i | input | 1 | Bus serial clock |
| si_i | input | 1 | Controller-to-target data |
| so_i | input | 1 | Target-to-controller data |
| bit_valid | output | 1 | One-cycle pulse per completed bit |
| bit_si | output | 1 | Controller-to-target value of the bit |
| bit_so | output | 1 | Target-to-controller value of the bit |
| bit_is_start | output | 1 | Bit is the start bit of the transfer |
| status_valid | output | 1 | One-cycle pulse per poll event |
| status_ready | output | 1 | 1 = ready, 0 = busy |
| frame_valid | output | 1 | One-cycle pulse when a transfer's buffer is complete |
| frame_count | output | $clog2(MAX_BITS+1) | Number of stored bits |
| frame_si | output | MAX_BITS | Stored controller-to-target bits, bit 0 first |
| frame_so | output | MAX_BITS | Stored target-to-controller bits, bit 0 first |
| warn | output | 2 | Sticky: [0] clock high at select, [1] buffer overflow |

## Verification
The embedded assertions check several properties on every cycle:
- a reported start bit is always high;
- a poll event seen while still selected always reports ready;
- `frame_valid` never lasts two cycles;
- the stored count never exceeds the buffer;
- the overflow flag is clear right after a new select interval opens.

Only the bench scenarios can show the rest:
- the correct pairing of data-line values with the rising and falling clock edges;
- the classification of each window;
- the dropping of a bit cut off by select falling while the clock is high;
- the absence of a phantom edge when the clock starts high;
- the exact buffer contents.

// File: rtl/uwire_monitor.sv
module uwire_monitor #(
  parameter int MAX_BITS = 16,
  localparam int CW = $clog2(MAX_BITS + 1),
  localparam int IW = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_i,
  input  logic                sk_i,
  input  logic                si_i,
  input  logic                so_i,
  output logic                bit_valid,
  output logic                bit_si,
  output logic                bit_so,
  output logic                bit_is_start,
  output logic                status_valid,
  output logic                status_ready,
  output logic                frame_valid,
  output logic [CW-1:0]       frame_count,
  output logic [MAX_BITS-1:0] frame_si,
  output logic [MAX_BITS-1:0] frame_so,
  output logic [1:0]          warn
);

  logic [3:0] sync1, sync2;
  logic cs_s, sk_s, si_s, so_s;
  logic cs_d, sk_d, so_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      cs_d  <= 1'b0;
      sk_d  <= 1'b0;
      so_d  <= 1'b0;
    end else begin
      sync1 <= {cs_i, sk_i, si_i, so_i};
      sync2 <= sync1;
      cs_d  <= cs_s;
      sk_d  <= sk_s;
      so_d  <= so_s;
    end
  end

  assign {cs_s, sk_s, si_s, so_s} = sync2;

  wire cs_rise = cs_s & ~cs_d;
  wire cs_fall = ~cs_s & cs_d;
  wire in_win  = cs_s & cs_d;
  wire sk_rise = in_win & sk_s & ~sk_d;
  wire sk_fall = in_win & ~sk_s & sk_d;
  wire so_rise = in_win & so_s & ~so_d;

  logic seen, data_mode, open, first, held_si, held_so, fin_q;
  logic [CW-1:0] cnt;

  wire emit = data_mode & open & (sk_rise | (cs_fall & ~sk_s));
  wire room = cnt < CW'(MAX_BITS);

  assign frame_count = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0; data_mode <= 1'b0; open <= 1'b0; first <= 1'b0;
      held_si <= 1'b0; held_so <= 1'b0; fin_q <= 1'b0;
      cnt <= '0; frame_si <= '0; frame_so <= '0; warn <= '0;
      bit_valid <= 1'b0; bit_si <= 1'b0; bit_so <= 1'b0; bit_is_start <= 1'b0;
      status_valid <= 1'b0; status_ready <= 1'b0; frame_valid <= 1'b0;
    end else begin
      bit_valid    <= 1'b0;
      status_valid <= 1'b0;
      fin_q        <= 1'b0;
      frame_valid  <= fin_q;

      if (cs_rise) begin
        seen <= 1'b0; data_mode <= 1'b0; open <= 1'b0; first <= 1'b1;
        held_so <= 1'b0; cnt <= '0; frame_si <= '0; frame_so <= '0;
        warn <= {1'b0, sk_s};
      end

      if (sk_rise) begin
        if (!seen) begin
          seen      <= 1'b1;
          data_mode <= si_s;
          open      <= si_s;
          held_si   <= si_s;
        end else if (data_mode) begin
          open    <= 1'b1;
          held_si <= si_s;
        end
      end

      if (sk_fall) held_so <= so_s;

      if (emit) begin
        bit_valid    <= 1'b1;
        bit_si       <= held_si;
        bit_so       <= held_so;
        bit_is_start <= first;
        first        <= 1'b0;
        if (room) begin
          frame_si[cnt[IW-1:0]] <= held_si;
          frame_so[cnt[IW-1:0]] <= held_so;
          cnt <= cnt + 1'b1;
        end else begin
          warn[1] <= 1'b1;
        end
      end

      if (cs_fall) begin
        open <= 1'b0;
        if (data_mode) fin_q <= 1'b1;
        else begin
          status_valid <= 1'b1;
          status_ready <= so_s;
        end
      end else if (so_rise && !data_mode) begin
        status_valid <= 1'b1;
        status_ready <= 1'b1;
      end
    end
  end

  a_r5_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_is_start) |-> bit_si);

  a_r7_event_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (status_valid && cs_d) |-> status_ready);

  a_r8_frame_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    frame_count <= CW'(MAX_BITS));

  a_r10_warn_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !warn[1]);

  a_r5_kind_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_valid && status_valid));

endmodule

// File: tb/uwire_monitor_tb.sv
module uwire_monitor_tb;
  localparam int CLK_PER = 10;
  localparam int MB = 8;
  localparam int CW = $clog2(MB + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, si = 1'b0, so = 1'b0;
  logic bit_valid, bit_si, bit_so, bit_is_start, status_valid, status_ready, frame_valid;
  logic [CW-1:0] frame_count;
  logic [MB-1:0] frame_si, frame_so;
  logic [1:0] warn;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct {
    int kind;
    logic a, b, c;
    int n;
    logic [MB-1:0] vs, vo;
  } item_t;
  item_t exp_q[$];

  always #(CLK_PER/2) clk = ~clk;

  uwire_monitor #(.MAX_BITS(MB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .si_i(si), .so_i(so),
    .bit_valid(bit_valid), .bit_si(bit_si), .bit_so(bit_so), .bit_is_start(bit_is_start),
    .status_valid(status_valid), .status_ready(status_ready),
    .frame_valid(frame_valid), .frame_count(frame_count),
    .frame_si(frame_si), .frame_so(frame_so), .warn(warn));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input int kind, input logic a, input logic b, input logic c,
                      input int n, input logic [MB-1:0] vs, input logic [MB-1:0] vo);
    item_t it;
    it.kind = kind; it.a = a; it.b = b; it.c = c; it.n = n; it.vs = vs; it.vo = vo;
    exp_q.push_back(it);
  endtask

  // Monitor: compares pulses in output order against the queue (R3 R4 R5 R6 R7 R8)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (bit_valid) begin
        if (exp_q.size() == 0 || exp_q[0].kind != 0)
          check(0, "R6 unexpected bit", int'(bit_si), -1);
        else begin
          check(bit_si == exp_q[0].a, "R3 si", int'(bit_si), int'(exp_q[0].a));
          check(bit_so == exp_q[0].b, "R4 so", int'(bit_so), int'(exp_q[0].b));
          check(bit_is_start == exp_q[0].c, "R5 start", int'(bit_is_start), int'(exp_q[0].c));
          void'(exp_q.pop_front());
        end
      end
      if (frame_valid) begin
        if (exp_q.size() == 0 || exp_q[0].kind != 2)
          check(0, "R8 unexpected frame", int'(frame_count), -1);
        else begin
          check(int'(frame_count) == exp_q[0].n, "R8 count", int'(frame_count), exp_q[0].n);
          check(frame_si == exp_q[0].vs, "R8 si vector", int'(frame_si), int'(exp_q[0].vs));
          check(frame_so == exp_q[0].vo, "R8 so vector", int'(frame_so), int'(exp_q[0].vo));
          void'(exp_q.pop_front());
        end
      end
      if (status_valid) begin
        if (exp_q.size() == 0 || exp_q[0].kind != 1)
          check(0, "R7 unexpected status", int'(status_ready), -1);
        else begin
          check(status_ready == exp_q[0].a, "R7 ready", int'(status_ready), int'(exp_q[0].a));
          void'(exp_q.pop_front());
        end
      end
    end
  end

  // Driver: clocks n bits in an open window; optionally ends with clock high.
  task automatic run_bits(input int n, input logic [15:0] sv, input logic [15:0] ov,
                          input bit end_high);
    logic [MB-1:0] es = '0, eo = '0;
    int kept = 0;
    for (int i = 0; i < n; i++) begin
      si = sv[i]; step();
      sk = 1'b1; step();
      so = ov[i]; step();
      if (end_high && i == n - 1) break;
      sk = 1'b0; step();
      push(0, sv[i], ov[i], i == 0, 0, '0, '0);
      if (i < MB) begin es[i] = sv[i]; eo[i] = ov[i]; kept++; end
    end
    push(2, 0, 0, 0, kept, es, eo);
    cs = 1'b0; step();
    sk = 1'b0; so = 1'b0; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step();
    // R1 reset state
    check({bit_valid, status_valid, frame_valid} == 3'b000, "R1 pulses", 0, 0);
    check(warn == 2'b00 && frame_count == '0, "R1 warn/count", int'(warn), 0);

    // Bit transfer, 5 bits (R3 R4 R5 R6 R8)
    cs = 1'b1; step();
    run_bits(5, 16'b10111, 16'b01010, 0);
    check(warn == 2'b00, "R2 no warning", int'(warn), 0);

    // Poll without clock: two ready rises, ends ready (R7)
    cs = 1'b1; step();
    so = 1'b1; push(1, 1, 0, 0, 0, '0, '0); step();
    so = 1'b0; step();
    so = 1'b1; push(1, 1, 0, 0, 0, '0, '0); step();
    push(1, 1, 0, 0, 0, '0, '0);
    cs = 1'b0; step();
    so = 1'b0; step();

    // Poll via low SI at first clock rise, busy at close (R5 R7)
    cs = 1'b1; step();
    si = 1'b0; sk = 1'b1; step();
    sk = 1'b0; step();
    sk = 1'b1; si = 1'b1; step();
    sk = 1'b0; step();
    push(1, 0, 0, 0, 0, '0, '0);
    cs = 1'b0; step();

    // Clock high at select (R2, R10)
    sk = 1'b1; step();
    cs = 1'b1; step();
    check(warn[0] == 1'b1, "R2 clock-high warning", int'(warn), 1);
    sk = 1'b0; step();
    run_bits(3, 16'b011, 16'b110, 0);
    check(warn[0] == 1'b1, "R10 sticky", int'(warn), 1);

    // Select falls with clock high: open bit dropped (R6)
    cs = 1'b1; step();
    check(warn == 2'b00, "R10 cleared", int'(warn), 0);
    run_bits(3, 16'b111, 16'b101, 1);

    // Overflow: 10 bits into an 8-bit buffer (R9)
    cs = 1'b1; step();
    run_bits(10, 16'b1101100111, 16'b0110011010, 0);
    check(warn[1] == 1'b1, "R9 overflow flag", int'(warn), 2);
    check(int'(frame_count) == MB, "R9 count saturates", int'(frame_count), MB);

    // Next select clears overflow (R10)
    cs = 1'b1; step();
    check(warn == 2'b00, "R10 cleared after overflow", int'(warn), 0);
    cs = 1'b0; push(1, 0, 0, 0, 0, '0, '0); step();

    step();
    check(exp_q.size() == 0, "R6 all expected items seen", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule